// File: doc/BRIEF.md
# Two-Step Half-Flash Conversion Sequencer

This block is the digital control for an 8-bit converter that reuses one 15-comparator flash stage twice. A falling edge on the sample strobe takes the comparators out of auto-zero and starts a conversion. The first pass turns the comparator thermometer code into the upper nibble. That nibble drives a 4-bit residue DAC. After a settling phase, a second pass on the residue gives the lower nibble.

The two nibbles are joined into one result that comes with a single-cycle valid pulse. The comparators then go straight back to acquisition/auto-zero. Each phase lasts a fixed number of clock cycles, set by a parameter, and these counts take the place of analog one-shot timers.

Two faults are reported at the ports:
- A thermometer word that is not monotonic is still counted by its number of ones, and an error flag is raised with the result.
- A strobe edge that arrives while a conversion is running has no effect, apart from a one-cycle overrun pulse.

Top module: `hf_seq_top`

## Requirements
- R1: After synchronous reset, `cmp_autozero_o` is 1, and `valid_o`, `dac_en_o`, `overrun_o`, `code_err_o`, `result_o` and `dac_code_o` are all 0.
- R2: A conversion starts only on a 1-to-0 transition of `sample_i` seen at a clock edge. From the cycle after that edge, `cmp_autozero_o` is 0. A 0-to-1 transition, or a steady level, leaves the block in auto-zero.
- R3: The coarse nibble is the number of ones in `cmp_i` at the end of the coarse phase. Bit k of `cmp_i` is 1 when the input level exceeds k, so all zeros gives 0 and all ones gives 15. This nibble appears on `dac_code_o`, and it stays unchanged for as long as `dac_en_o` is 1 (the settle and fine phases).
- R4: The fine nibble is the number of ones in `cmp_i` at the end of the fine phase. `result_o` equals {coarse nibble, fine nibble}, with the coarse nibble in bits 7:4.
- R5: `valid_o` is high for exactly one cycle. It rises at clock edge E+T_COARSE+T_SETTLE+T_FINE, where E is the edge that sees the strobe fall.
- R6: In the cycle where `valid_o` is high, `cmp_autozero_o` is already 1 and `dac_en_o` is 0.
- R7: If the thermometer word of either pass is not of the form 2^n-1, that pass is still converted by its number of ones, and `code_err_o` is 1 alongside the result. Otherwise `code_err_o` is 0.
- R8: A strobe falling edge seen while a conversion runs does not restart or change that conversion. It gives a one-cycle `overrun_o` pulse in the cycle after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_i | input | 1 | Sample strobe; its falling edge starts a conversion |
| cmp_i | input | 15 | Flash comparator thermometer outputs |
| cmp_autozero_o | output | 1 | Comparators in acquisition/auto-zero |
| dac_code_o | output | 4 | Coarse nibble to the residue DAC |
| dac_en_o | output | 1 | Residue path active (settle and fine phases) |
| result_o | output | 8 | Converted code |
| valid_o | output | 1 | One-cycle result strobe |
| code_err_o | output | 1 | Non-monotonic thermometer seen in this conversion |
| overrun_o | output | 1 | Strobe edge ignored while busy |

## Verification
Some properties are checked by assertions on every cycle:
- `valid_o` is a single-cycle pulse, and it always comes out of the fine phase.
- The DAC code holds steady while the residue path is active.
- Auto-zero and the residue path are never active together.
- An overrun pulse appears only when a conversion was running.

Other properties can only be shown by the bench's scenarios, which use a behavioural comparator and DAC model:
- That the result equals the applied level.
- The exact latency.
- That a rising strobe edge starts nothing.
- That a strobe edge during a conversion leaves the result untouched.
- That a bubbled thermometer is counted by its ones.

// File: rtl/hf_seq_pkg.sv
package hf_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_COARSE = 2'd1,
    PH_SETTLE = 2'd2,
    PH_FINE   = 2'd3
  } phase_e;
endpackage

// File: rtl/hf_fall_detect.sv
module hf_fall_detect (
  input  logic clk,
  input  logic rst,
  input  logic strobe_i,
  output logic fall_o
);
  logic strobe_q;

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= strobe_i;
  end

  assign fall_o = strobe_q & ~strobe_i;
endmodule

// File: rtl/hf_therm_decode.sv
module hf_therm_decode #(
  parameter int N_BITS = 4
) (
  input  logic [(1<<N_BITS)-2:0] therm_i,
  output logic [N_BITS-1:0]      level_o,
  output logic                   bubble_o
);
  localparam int TAPS = (1 << N_BITS) - 1;

  logic [N_BITS:0] ones;
  logic [TAPS-1:0] ideal;

  always_comb begin
    ones = '0;
    for (int i = 0; i < TAPS; i++) begin
      ones = ones + (N_BITS+1)'(therm_i[i]);
    end
  end

  generate
    for (genvar g = 0; g < TAPS; g++) begin : g_ideal
      assign ideal[g] = (32'(g) < 32'(ones));
    end
  endgenerate

  assign level_o  = ones[N_BITS-1:0];
  assign bubble_o = (ideal != therm_i);
endmodule

// File: rtl/hf_phase_timer.sv
module hf_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          done_o
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load_i)      cnt <= load_val_i;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done_o = (cnt == '0);
endmodule

// File: rtl/hf_seq_top.sv
module hf_seq_top #(
  parameter int N_BITS   = 4,
  parameter int T_COARSE = 3,
  parameter int T_SETTLE = 2,
  parameter int T_FINE   = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sample_i,
  input  logic [(1<<N_BITS)-2:0]  cmp_i,
  output logic                    cmp_autozero_o,
  output logic [N_BITS-1:0]       dac_code_o,
  output logic                    dac_en_o,
  output logic [2*N_BITS-1:0]     result_o,
  output logic                    valid_o,
  output logic                    code_err_o,
  output logic                    overrun_o
);
  import hf_seq_pkg::*;

  localparam int T_MAX = (T_COARSE > T_SETTLE) ?
                         ((T_COARSE > T_FINE) ? T_COARSE : T_FINE) :
                         ((T_SETTLE > T_FINE) ? T_SETTLE : T_FINE);
  localparam int CW = $clog2(T_MAX + 1);

  phase_e            phase;
  logic              fall;
  logic [N_BITS-1:0] level;
  logic              bubble;
  logic              t_load, t_done;
  logic [CW-1:0]     t_val;
  logic [N_BITS-1:0] msb_q;
  logic              bub_q;

  hf_fall_detect i_edge (
    .clk(clk), .rst(rst), .strobe_i(sample_i), .fall_o(fall)
  );

  hf_therm_decode #(.N_BITS(N_BITS)) i_dec (
    .therm_i(cmp_i), .level_o(level), .bubble_o(bubble)
  );

  hf_phase_timer #(.CW(CW)) i_tmr (
    .clk(clk), .rst(rst), .load_i(t_load), .load_val_i(t_val), .done_o(t_done)
  );

  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    unique case (phase)
      PH_IDLE:   if (fall)   begin t_load = 1'b1; t_val = CW'(T_COARSE - 1); end
      PH_COARSE: if (t_done) begin t_load = 1'b1; t_val = CW'(T_SETTLE - 1); end
      PH_SETTLE: if (t_done) begin t_load = 1'b1; t_val = CW'(T_FINE - 1);   end
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      msb_q      <= '0;
      bub_q      <= 1'b0;
      result_o   <= '0;
      valid_o    <= 1'b0;
      code_err_o <= 1'b0;
      overrun_o  <= 1'b0;
    end else begin
      valid_o   <= 1'b0;
      overrun_o <= fall && (phase != PH_IDLE);
      unique case (phase)
        PH_IDLE: if (fall) phase <= PH_COARSE;
        PH_COARSE: if (t_done) begin
          msb_q <= level;
          bub_q <= bubble;
          phase <= PH_SETTLE;
        end
        PH_SETTLE: if (t_done) phase <= PH_FINE;
        PH_FINE: if (t_done) begin
          result_o   <= {msb_q, level};
          code_err_o <= bub_q | bubble;
          valid_o    <= 1'b1;
          phase      <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign cmp_autozero_o = (phase == PH_IDLE);
  assign dac_en_o       = (phase == PH_SETTLE) || (phase == PH_FINE);
  assign dac_code_o     = msb_q;

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o); // R5
  AST_VALID_FROM_FINE: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_o) |-> $past(phase == PH_FINE)); // R5
  AST_DAC_HELD: assert property (@(posedge clk) disable iff (rst)
    (dac_en_o && $past(dac_en_o)) |-> $stable(dac_code_o)); // R3
  AST_AZ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(cmp_autozero_o && dac_en_o)); // R6
  AST_VALID_IN_AZ: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> cmp_autozero_o); // R6
  AST_OVERRUN_BUSY: assert property (@(posedge clk) disable iff (rst)
    overrun_o |-> $past(phase != PH_IDLE)); // R8
endmodule

// File: tb/test_hf_seq_top.sv
module test_hf_seq_top;
  localparam int TC = 3, TS = 2, TF = 3;
  localparam int LAT = TC + TS + TF + 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sample = 1'b1;
  logic [14:0] cmp;
  logic        az, dac_en, valid, err, ovr;
  logic [3:0]  dac_code;
  logic [7:0]  result;

  logic [7:0]  vin = 8'd0;
  logic        force_on = 1'b0;
  logic [14:0] force_pat = '0;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  hf_seq_top #(.N_BITS(4), .T_COARSE(TC), .T_SETTLE(TS), .T_FINE(TF)) i_hf_seq_top (
    .clk(clk), .rst(rst), .sample_i(sample), .cmp_i(cmp),
    .cmp_autozero_o(az), .dac_code_o(dac_code), .dac_en_o(dac_en),
    .result_o(result), .valid_o(valid), .code_err_o(err), .overrun_o(ovr)
  );

  function automatic logic [14:0] therm(input int lvl);
    return 15'((32'd1 << lvl) - 1);
  endfunction

  always_comb begin
    int lvl;
    if (dac_en) begin
      lvl = int'(vin) - 16 * int'(dac_code);
      if (lvl < 0)  lvl = 0;
      if (lvl > 15) lvl = 15;
    end else begin
      lvl = int'(vin) >> 4;
    end
    cmp = therm(lvl);
    if (force_on && !dac_en) cmp = force_pat;
  end

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic convert(input logic [7:0] v, input bit inject,
                         input int exp_res, input int exp_err, input int exp_msb);
    int cnt = 0;
    int ovr_seen = 0;
    bit got = 0;
    vin = v;
    @(negedge clk);
    sample = 1'b0;
    while (!got) begin
      @(negedge clk);
      cnt++;
      if (cnt == 1) check("R2 autozero low after fall", int'(az), 0);
      if (inject && cnt == 3) sample = 1'b1;
      if (inject && cnt == 4) sample = 1'b0;
      if (ovr) ovr_seen++;
      if (inject && cnt == 5) check("R8 overrun pulse timing", int'(ovr), 1);
      if (dac_en && cnt == LAT - 1) check("R3 dac code", int'(dac_code), exp_msb);
      if (valid) begin
        got = 1;
        check("R5 latency", cnt, LAT);
        check("R4 result", int'(result), exp_res);
        check("R7 code error flag", int'(err), exp_err);
        check("R6 autozero with valid", int'(az), 1);
      end
      if (cnt > 100) begin
        check("R5 watchdog", cnt, LAT);
        got = 1;
      end
    end
    check("R8 overrun count", ovr_seen, inject ? 1 : 0);
    sample = 1'b1;
    @(negedge clk);
    check("R5 valid single cycle", int'(valid), 0);
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 autozero", int'(az), 1);
    check("R1 valid", int'(valid), 0);
    check("R1 dac_en", int'(dac_en), 0);
    check("R1 overrun", int'(ovr), 0);
    check("R1 err", int'(err), 0);
    check("R1 result", int'(result), 0);
    check("R1 dac code", int'(dac_code), 0);

    // R2: a rising edge and steady levels start nothing
    sample = 1'b0;
    repeat (2) @(negedge clk);
    sample = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check("R2 rising edge ignored", int'(az), 1);
    end

    // Directed corners (R3 all zeros / all ones)
    convert(8'h00, 0, 8'h00, 0, 0);
    convert(8'hFF, 0, 8'hFF, 0, 15);
    convert(8'h10, 0, 8'h10, 0, 1);
    convert(8'hEF, 0, 8'hEF, 0, 14);

    // R7: bubbled coarse thermometer, counted by ones (2)
    force_on = 1'b1;
    force_pat = 15'b000_0000_0000_0101;
    convert(8'd40, 0, 8'h28, 1, 2);
    force_pat = 15'b100_0000_0000_0011;
    convert(8'd80, 0, {4'd3, 4'd15}, 1, 3);
    force_on = 1'b0;

    // R8: a second falling edge mid-conversion is ignored
    convert(8'hA7, 1, 8'hA7, 0, 10);
    convert(8'h5C, 0, 8'h5C, 0, 5);

    for (int k = 0; k < 30; k++) begin
      logic [7:0] v;
      v = 8'($urandom);
      convert(v, (k % 7) == 3, int'(v), 0, int'(v >> 4));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule